// File: doc/BRIEF.md
# Boot-Streaming Serial Flash Responder

This block sits on the device side of a four-wire serial flash link and answers reads from an internal byte array. After every reset it arms a boot stream. On the first chip-select assertion the host gets data with no command and no address. A programmable number of idle clocks comes first, then bytes from a preset start address, one after another, for as long as the host keeps clocking. When that first select is released the block disarms. From then on, each transaction is decoded as an ordinary read command.

The serial pins are sampled on the system clock, and edges of the serial clock and chip select are detected internally. The link follows mode 0 timing: the host drives the command line before each rising serial-clock edge and samples the read data on that edge. The block moves its output on the falling edge. Three other inputs are plain: a configuration write that sets the start address, the warm-up count and the boot enable, and a byte write port that fills the array. The serial link has no back-pressure. Data advances only when the host clocks, and it stops when the host stops.

Top module: `autoboot_flash_resp`

## Requirements
- R1: While reset is held, and after it is released with chip select high, the read-data enable `spi_miso_oe` is 0 and `spi_miso` is 0.
- R2: When boot is enabled, the first chip-select assertion after reset streams bytes from the configured start address. The command line is ignored throughout this transaction.
- R3: In a boot transaction with warm-up count N > 0, the output enable stays 0 at the first N rising serial-clock edges. The MSB of the first byte is presented for the (N+1)th rising edge.
- R4: Bytes go out MSB first. The output changes only after a falling serial-clock edge or a chip-select change. Each further byte comes from the next address.
- R5: The address counter wraps from the last array location (2^ADDR_W-1) to location 0.
- R6: After the first chip-select release following reset, a transaction is a read only if its first 8 bits, taken MSB first on rising edges, equal 0x03. Those bits are followed by 24 address bits, MSB first, and only the low ADDR_W bits are used. The first data bit is driven for the 33rd rising edge. The output enable is 0 during the command and address bits.
- R7: Any other opcode leaves the output enable at 0 until chip select is released.
- R8: With the boot enable cleared, the first transaction after reset is decoded as a command, as in R6.
- R9: With warm-up count 0, the MSB of the first boot byte is valid at the first rising edge, right after chip select falls.
- R10: Raising chip select drops the output enable on the next system clock. This holds even when the rise coincides with a falling serial-clock edge, and an unfinished byte is abandoned.
- R11: Configuration writes take effect at the next chip-select assertion. Array writes change the data later reads return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset; arms the boot stream |
| spi_sck | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Command/address line from the host |
| spi_miso | output | 1 | Read data line |
| spi_miso_oe | output | 1 | High while read data is being driven |
| cfg_we | input | 1 | Loads the three configuration fields |
| cfg_start | input | ADDR_W | Boot start address |
| cfg_warm | input | WARM_W | Warm-up clock count before boot data |
| cfg_enable | input | 1 | Boot stream enable |
| init_we | input | 1 | Array byte write strobe |
| init_addr | input | ADDR_W | Array write address |
| init_data | input | 8 | Array write data |

## Verification
Two events can land in the same system cycle. One is the chip-select release; the other is a falling serial-clock edge that would shift or reload the output byte. The bench provokes this by dropping the serial clock and raising chip select in the same cycle, partway through a boot byte. The release must win: the enable drops at once, the boot stream disarms, and the next select must behave as a command transaction. A second collision happens at a zero warm-up count, where the chip-select fall and the first byte load occur together. It is checked with a start address at the top of the array, so the wrap happens on that same load.

// File: rtl/autoboot_pkg.sv
package autoboot_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WARM,
    ST_CMD,
    ST_ADDR,
    ST_LOAD,
    ST_DATA,
    ST_SKIP
  } ab_state_e;

  localparam logic [7:0] OPC_READ = 8'h03;
  localparam int ADDR_BITS_ON_WIRE = 24;
endpackage

// File: rtl/ab_edges.sv
module ab_edges #(
  parameter int N = 2,
  parameter logic [N-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= IDLE;
    else        pin_q <= pin;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign rise[i] = pin[i] & ~pin_q[i];
    assign fall[i] = ~pin[i] & pin_q[i];
  end
endmodule

// File: rtl/ab_cfg.sv
module ab_cfg #(
  parameter int ADDR_W = 8,
  parameter int WARM_W = 4,
  parameter logic [ADDR_W-1:0] DEF_START = '0,
  parameter logic [WARM_W-1:0] DEF_WARM = '0,
  parameter logic DEF_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] start_in,
  input  logic [WARM_W-1:0] warm_in,
  input  logic              en_in,
  output logic [ADDR_W-1:0] start_q,
  output logic [WARM_W-1:0] warm_q,
  output logic              en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= DEF_START;
      warm_q  <= DEF_WARM;
      en_q    <= DEF_EN;
    end else if (we) begin
      start_q <= start_in;
      warm_q  <= warm_in;
      en_q    <= en_in;
    end
  end
endmodule

// File: rtl/ab_array.sv
module ab_array #(
  parameter int ADDR_W = 8,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ab_seq.sv
module ab_seq
  import autoboot_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WARM_W = 4,
  localparam int SH_W = (ADDR_W > 8) ? ADDR_W : 8,
  localparam int CNT_W = $clog2(ADDR_BITS_ON_WIRE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              mosi,
  input  logic [ADDR_W-1:0] boot_start,
  input  logic [WARM_W-1:0] boot_warm,
  input  logic              boot_en,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              byte_load,
  output logic              armed,
  output logic              miso,
  output logic              miso_oe
);
  ab_state_e         state;
  logic [ADDR_W-1:0] addr_q;
  logic [SH_W-2:0]   in_sh;
  logic [SH_W-1:0]   sh_next;
  logic [CNT_W-1:0]  cnt;
  logic [WARM_W-1:0] wcnt;
  logic [3:0]        bitcnt;
  logic [7:0]        out_sh;
  logic              boot_go;
  logic              boot_now;

  assign boot_go  = cs_fall && armed && boot_en;
  assign boot_now = boot_go && (boot_warm == '0);
  assign rd_addr  = boot_now ? boot_start : addr_q;
  assign sh_next  = {in_sh, mosi};

  assign byte_load = !cs_rise && (boot_now ||
                     (sck_fall && state == ST_LOAD) ||
                     (sck_fall && state == ST_DATA && bitcnt == 4'd8));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      armed  <= 1'b1;
      addr_q <= '0;
      in_sh  <= '0;
      cnt    <= '0;
      wcnt   <= '0;
      bitcnt <= '0;
      out_sh <= '0;
    end else if (cs_rise) begin
      state <= ST_IDLE;
      armed <= 1'b0;
    end else if (byte_load) begin
      out_sh <= rd_data;
      addr_q <= rd_addr + 1'b1;
      bitcnt <= '0;
      state  <= ST_DATA;
    end else if (cs_fall) begin
      cnt  <= '0;
      wcnt <= '0;
      if (boot_go) begin
        addr_q <= boot_start;
        state  <= ST_WARM;
      end else begin
        state <= ST_CMD;
      end
    end else begin
      case (state)
        ST_WARM: if (sck_rise) begin
          wcnt <= wcnt + 1'b1;
          if (wcnt == boot_warm - 1'b1) state <= ST_LOAD;
        end
        ST_CMD: if (sck_rise) begin
          in_sh <= sh_next[SH_W-2:0];
          cnt   <= cnt + 1'b1;
          if (cnt == CNT_W'(7)) begin
            cnt   <= '0;
            state <= (sh_next[7:0] == OPC_READ) ? ST_ADDR : ST_SKIP;
          end
        end
        ST_ADDR: if (sck_rise) begin
          in_sh <= sh_next[SH_W-2:0];
          cnt   <= cnt + 1'b1;
          if (cnt == CNT_W'(ADDR_BITS_ON_WIRE - 1)) begin
            addr_q <= sh_next[ADDR_W-1:0];
            state  <= ST_LOAD;
          end
        end
        ST_DATA: begin
          if (sck_rise) bitcnt <= bitcnt + 1'b1;
          if (sck_fall) out_sh <= {out_sh[6:0], 1'b0};
        end
        default: ;
      endcase
    end
  end

  assign miso_oe = (state == ST_DATA);
  assign miso    = miso_oe & out_sh[7];
endmodule

// File: rtl/autoboot_flash_resp.sv
module autoboot_flash_resp #(
  parameter int ADDR_W = 8,
  parameter int WARM_W = 4,
  parameter logic [ADDR_W-1:0] DEF_START = ADDR_W'(16),
  parameter logic [WARM_W-1:0] DEF_WARM = WARM_W'(3),
  parameter logic DEF_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_start,
  input  logic [WARM_W-1:0] cfg_warm,
  input  logic              cfg_enable,
  input  logic              init_we,
  input  logic [ADDR_W-1:0] init_addr,
  input  logic [7:0]        init_data
);
  logic [1:0]        pin_rise, pin_fall;
  logic              sck_rise, sck_fall, cs_rise, cs_fall;
  logic [ADDR_W-1:0] boot_start, rd_addr;
  logic [WARM_W-1:0] warm_cfg;
  logic              boot_en, armed, byte_load;
  logic [7:0]        rd_data;

  ab_edges #(.N(2), .IDLE(2'b10)) u_edges (
    .clk(clk), .rst_n(rst_n), .pin({spi_cs_n, spi_sck}),
    .rise(pin_rise), .fall(pin_fall)
  );
  assign sck_rise = pin_rise[0];
  assign sck_fall = pin_fall[0];
  assign cs_rise  = pin_rise[1];
  assign cs_fall  = pin_fall[1];

  ab_cfg #(
    .ADDR_W(ADDR_W), .WARM_W(WARM_W),
    .DEF_START(DEF_START), .DEF_WARM(DEF_WARM), .DEF_EN(DEF_EN)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we),
    .start_in(cfg_start), .warm_in(cfg_warm), .en_in(cfg_enable),
    .start_q(boot_start), .warm_q(warm_cfg), .en_q(boot_en)
  );

  ab_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .we(init_we), .waddr(init_addr), .wdata(init_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  ab_seq #(.ADDR_W(ADDR_W), .WARM_W(WARM_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .mosi(spi_mosi),
    .boot_start(boot_start), .boot_warm(warm_cfg), .boot_en(boot_en),
    .rd_data(rd_data), .rd_addr(rd_addr), .byte_load(byte_load),
    .armed(armed), .miso(spi_miso), .miso_oe(spi_miso_oe)
  );
endmodule

// File: rtl/ab_checker.sv
module ab_checker #(
  parameter int ADDR_W = 8,
  parameter int WARM_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              spi_cs_n,
  input logic              spi_miso,
  input logic              spi_miso_oe,
  input logic              sck_fall,
  input logic              cs_fall,
  input logic              cs_rise,
  input logic              armed,
  input logic              boot_en,
  input logic [WARM_W-1:0] warm_cfg,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              byte_load
);
  // R10
  release_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |=> !spi_miso_oe);

  // R3
  warm_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && armed && boot_en && warm_cfg != '0) |=> !spi_miso_oe);

  // R9
  zero_warm_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && armed && boot_en && warm_cfg == '0) |=> spi_miso_oe);

  // R6
  disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !armed);

  // R4
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall && !cs_fall && !spi_cs_n) |=> $stable(spi_miso));

  // R5
  addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_load && rd_addr == '1) |=> (rd_addr == '0));
endmodule

bind autoboot_flash_resp ab_checker #(.ADDR_W(ADDR_W), .WARM_W(WARM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
  .spi_miso_oe(spi_miso_oe), .sck_fall(sck_fall), .cs_fall(cs_fall),
  .cs_rise(cs_rise), .armed(armed), .boot_en(boot_en), .warm_cfg(warm_cfg),
  .rd_addr(rd_addr), .byte_load(byte_load)
);

// File: tb/tb_autoboot_flash_resp.sv
module tb_autoboot_flash_resp;
  localparam int AW = 8;
  localparam int WW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, miso_oe;
  logic cfg_we = 1'b0, cfg_en = 1'b1;
  logic [AW-1:0] cfg_start = '0;
  logic [WW-1:0] cfg_warm = '0;
  logic init_we = 1'b0;
  logic [AW-1:0] init_addr = '0;
  logic [7:0] init_data = '0;

  logic [7:0] model [DEPTH];
  int checks = 0, errors = 0, cycles = 0;

  autoboot_flash_resp #(.ADDR_W(AW), .WARM_W(WW)) dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(miso_oe), .cfg_we(cfg_we),
    .cfg_start(cfg_start), .cfg_warm(cfg_warm), .cfg_enable(cfg_en),
    .init_we(init_we), .init_addr(init_addr), .init_data(init_data)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sck_bit(input logic m, output logic b, output logic oe);
    mosi = m;
    b = miso;
    oe = miso_oe;
    sck = 1'b1;
    waitn(3);
    sck = 1'b0;
    waitn(3);
  endtask

  task automatic cs_on();
    cs_n = 1'b0;
    waitn(3);
  endtask

  task automatic cs_off();
    cs_n = 1'b1;
    waitn(3);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    waitn(3);
    rst_n = 1'b1;
    waitn(2);
  endtask

  task automatic set_cfg(input logic [AW-1:0] s, input logic [WW-1:0] w, input logic e);
    cfg_start = s; cfg_warm = w; cfg_en = e; cfg_we = 1'b1;
    waitn(1);
    cfg_we = 1'b0;
  endtask

  task automatic poke(input logic [AW-1:0] a, input logic [7:0] d);
    init_addr = a; init_data = d; init_we = 1'b1;
    waitn(1);
    init_we = 1'b0;
    model[a] = d;
  endtask

  task automatic read_byte(output logic [7:0] v, output bit oe_all);
    logic b, oe;
    oe_all = 1'b1;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      sck_bit(1'($urandom), b, oe);
      v = {v[6:0], b};
      oe_all &= oe;
    end
  endtask

  task automatic send_bits(input logic [31:0] val, input int n, output bit oe_any);
    logic b, oe;
    oe_any = 1'b0;
    for (int i = n - 1; i >= 0; i--) begin
      sck_bit(val[i], b, oe);
      oe_any |= oe;
    end
  endtask

  task automatic expect_bytes(input int start, input int n, input string req);
    logic [7:0] v;
    bit oe_all;
    for (int i = 0; i < n; i++) begin
      read_byte(v, oe_all);
      chk(oe_all && v == model[(start + i) % DEPTH], req, {oe_all, v},
          {1'b1, model[(start + i) % DEPTH]});
    end
  endtask

  task automatic cmd_read(input logic [7:0] op, input int a, input int n, input string req);
    bit oe_any;
    cs_on();
    send_bits({op, 24'(a)}, 32, oe_any);
    chk(!oe_any, "R6 quiet during command/address", oe_any, 0);
    if (op == 8'h03) expect_bytes(a % DEPTH, n, req);
    else begin
      send_bits(32'h0, 16, oe_any);
      chk(!oe_any, "R7 unknown opcode stays quiet", oe_any, 0);
    end
    cs_off();
  endtask

  task automatic boot_warm(input int w);
    bit oe_any;
    send_bits(32'($urandom), w, oe_any);
    chk(!oe_any, "R3 warm-up clocks quiet", oe_any, 0);
  endtask

  initial begin
    logic b, oe;
    logic [7:0] v;
    bit oe_all;
    int w;
    void'($urandom(32'd20240917));

    waitn(3);
    chk(miso_oe == 1'b0 && miso == 1'b0, "R1 reset outputs", {miso_oe, miso}, 0);
    rst_n = 1'b1;
    waitn(2);
    chk(miso_oe == 1'b0 && miso == 1'b0, "R1 after reset", {miso_oe, miso}, 0);

    for (int i = 0; i < DEPTH; i++) poke(AW'(i), 8'($urandom));

    // R2/R3/R4: default boot, start 0x10, three warm clocks
    cs_on();
    boot_warm(3);
    expect_bytes(16, 4, "R2 R4 boot stream");
    cs_off();
    chk(!miso_oe, "R10 release", miso_oe, 0);

    // R6 and R5: normal read crossing the array end
    cmd_read(8'h03, 32'hAB00FD, 5, "R5 R6 wrap read");
    cmd_read(8'h0B, 32'h000020, 0, "R7");
    for (int t = 0; t < 6; t++)
      cmd_read(8'h03, int'($urandom_range(0, 32'hFFFFFF)), int'($urandom_range(1, 4)), "R6 random read");

    // R9/R11/R5: zero warm-up from the last location
    do_reset();
    set_cfg(8'hFF, 4'd0, 1'b1);
    cs_on();
    expect_bytes(255, 3, "R9 R5 zero warm boot");
    cs_off();

    // R8: boot disabled, first select is a command
    do_reset();
    set_cfg(8'h40, 4'd2, 1'b0);
    cmd_read(8'h03, 32'h000020, 2, "R8 disabled boot decodes command");

    // R10 + R6: abort mid-byte with simultaneous release and falling edge
    do_reset();
    w = int'($urandom_range(1, 7));
    set_cfg(8'h40, WW'(w), 1'b1);
    cs_on();
    boot_warm(w);
    expect_bytes(64, 1, "R11 new start/warm");
    for (int i = 0; i < 3; i++) sck_bit(1'b0, b, oe);
    mosi = 1'b0;
    sck = 1'b1;
    waitn(3);
    sck = 1'b0;
    cs_n = 1'b1;
    waitn(1);
    chk(!miso_oe, "R10 release beats falling edge", miso_oe, 0);
    waitn(3);
    poke(8'h41, 8'h5A);
    cmd_read(8'h03, 32'h000041, 2, "R6 R11 after disarm");

    // R2: second reset re-arms with the stored defaults
    do_reset();
    cs_on();
    boot_warm(3);
    read_byte(v, oe_all);
    chk(oe_all && v == model[16], "R2 rearmed after reset", v, model[16]);
    cs_off();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule